// File: doc/BRIEF.md
# Monotonic-Switching SAR Conversion Sequencer

This block is the digital sequencer of a differential successive-approximation converter that uses monotonic capacitor switching. A high level on the sample-phase input means the analog front end is tracking the input onto the top plates. While that phase lasts, every bottom plate of both capacitor arrays is held at the reference. When the phase drops, the sequencer fires the comparator once per bit, from the most significant bit down. It issues one active bit-clock per comparison and captures each decision into the result word. After every decision except the last, it moves exactly one capacitor, the one of the next lower weight on the side whose input was higher, from the reference to ground. A capacitor never moves back until the conversion is over.

The ground and reference enables of each capacitor are separated by a configurable dead time, counted in clock cycles. No plate is ever driven to both rails at once. When the last bit has been captured, a one-cycle done pulse marks a valid word. Then all plates are returned to the reference, ground first, so the arrays are ready for the next sample phase. If the sample phase comes back while a conversion is still running, the conversion is abandoned without a done pulse and the plates are restored. The conversion rate is set by the clock: one conversion takes 2 + (2 + DEAD_CYC)·(NBITS − 1) cycles plus the restore.

The result leaves the block as a plain word plus a done strobe. It has no ready input and no back-pressure. The conversion timing is fixed by the analog phase, so the consumer must take the word while done is high. The word then stays stable until the next conversion starts.

Top module: `sar_mono_ctrl`

## Requirements
- R1: After reset, every reference enable is 1, every ground enable is 0, all bit clocks are 0, done is 0 and the result word is 0.
- R2: A conversion starts at the first clock edge at which the sample phase is low after it has been seen high. While the sequencer is idle with the sample phase high, all reference enables are 1 and all ground enables are 0.
- R3: Bit clocks are one-hot or zero. Bit clock k is high for one cycle, in order from NBITS−1 down to 0. It is high in the cycle after edge 1 + (2+DEAD_CYC)·(NBITS−1−k), counting edges from the start edge.
- R4: Result bit k equals the comparator input sampled while bit clock k is high. A value of 1 means the positive input is higher.
- R5: No capacitor is switched before the most significant decision. Decision k > 0 grounds capacitor k−1 on the positive array when it is 1, or on the negative array when it is 0. Decision 0 switches nothing.
- R6: No capacitor has its reference and ground enables high together. Each enable rises only after the other has been low for at least DEAD_CYC cycles.
- R7: Within a conversion, no reference enable rises.
- R8: Done is a single-cycle pulse that appears 2 + (2+DEAD_CYC)·(NBITS−1) edges after the start edge. The full result word is valid in that cycle and stays until the next start.
- R9: One edge after done, all ground enables are 0. DEAD_CYC edges later, all reference enables are 1.
- R10: A sample phase raised during a conversion aborts it without a done pulse. Within 2+DEAD_CYC edges all plates are back at the reference, and the next fall of the sample phase starts a fresh conversion.
- R11: With an ideal differential array driven by the enables, the result word is the offset-binary code floor((Vd/Vref + 1)·2^(NBITS−1)).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | 1 | Sample phase, high while tracking |
| cmp_p_gt_i | input | 1 | Comparator decision, 1 when the positive side is higher |
| bit_clk_o | output | NBITS | One-hot comparator fire strobes, bit k on index k |
| ref_en_p_o | output | NBITS-1 | Positive array bottom-plate reference enables |
| gnd_en_p_o | output | NBITS-1 | Positive array bottom-plate ground enables |
| ref_en_n_o | output | NBITS-1 | Negative array bottom-plate reference enables |
| gnd_en_n_o | output | NBITS-1 | Negative array bottom-plate ground enables |
| code_o | output | NBITS | Conversion result, offset binary |
| done_o | output | 1 | One-cycle pulse, result valid |

## Verification
With the default ten bits and one dead cycle, strobe k is due after edge 1 + 3·(9−k) and done after edge 29. The ground enables clear one edge after done and the reference enables return one edge later. After an abort, the plates are back at the reference three edges after the sample phase rises. The bench drives inputs just after a falling edge and counts rising edges from there. It reads the outputs on the following falling edges and compares each result against the edge number at which it is due. The comparator input comes from an ideal array model that sums the grounded capacitor weights. A sweep over every code therefore checks both the word and the switching pattern that produced it.

// File: rtl/sar_mono_pkg.sv
package sar_mono_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STROBE,
    ST_DEAD,
    ST_SETTLE,
    ST_LIFT,
    ST_RDEAD
  } sar_state_e;

  localparam int SIDE_N = 0;
  localparam int SIDE_P = 1;
endpackage

// File: rtl/sar_seq.sv
module sar_seq
  import sar_mono_pkg::*;
#(
  parameter int NBITS    = 10,
  parameter int DEAD_CYC = 1,
  localparam int IW  = $clog2(NBITS),
  localparam int NCAP = NBITS - 1,
  localparam int CIW = (NCAP > 1) ? $clog2(NCAP) : 1,
  localparam int CW  = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_i,
  input  logic             cmp_i,
  output logic [NBITS-1:0] bit_clk_o,
  output logic             idle_o,
  output logic             start_o,
  output logic             capture_o,
  output logic [IW-1:0]    idx_o,
  output logic             rel_o,
  output logic             rel_side_o,
  output logic [CIW-1:0]   rel_cap_o,
  output logic             gnd_go_o,
  output logic             lift_o,
  output logic             reref_o
);
  sar_state_e    state_q;
  logic [IW-1:0] idx_q;
  logic [CW-1:0] cnt_q;
  logic          armed_q;
  logic          cnt_end;

  assign cnt_end    = (cnt_q == CW'(DEAD_CYC - 1));
  assign idle_o     = (state_q == ST_IDLE);
  assign start_o    = idle_o && armed_q && !sample_i;
  assign capture_o  = (state_q == ST_STROBE) && !sample_i;
  assign idx_o      = idx_q;
  assign rel_o      = capture_o && (idx_q != '0);
  assign rel_side_o = cmp_i;
  assign rel_cap_o  = CIW'(idx_q - IW'(1));
  assign gnd_go_o   = (state_q == ST_DEAD) && cnt_end && !sample_i;
  assign lift_o     = (state_q == ST_LIFT);
  assign reref_o    = (state_q == ST_RDEAD) && cnt_end;

  for (genvar k = 0; k < NBITS; k++) begin : g_strobe
    assign bit_clk_o[k] = (state_q == ST_STROBE) && (idx_q == IW'(k));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else if (start_o) armed_q <= 1'b0;
    else if (sample_i) armed_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_o) begin
          state_q <= ST_STROBE;
          idx_q   <= IW'(NBITS - 1);
        end
        ST_STROBE: begin
          cnt_q <= '0;
          if (sample_i || idx_q == '0) state_q <= ST_LIFT;
          else state_q <= ST_DEAD;
        end
        ST_DEAD: begin
          if (sample_i) state_q <= ST_LIFT;
          else if (cnt_end) state_q <= ST_SETTLE;
          else cnt_q <= cnt_q + CW'(1);
        end
        ST_SETTLE: begin
          if (sample_i) state_q <= ST_LIFT;
          else begin
            state_q <= ST_STROBE;
            idx_q   <= idx_q - IW'(1);
          end
        end
        ST_LIFT: begin
          state_q <= ST_RDEAD;
          cnt_q   <= '0;
        end
        ST_RDEAD: begin
          if (cnt_end) state_q <= ST_IDLE;
          else cnt_q <= cnt_q + CW'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_strobe_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bit_clk_o));
  p_strobe_short_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|bit_clk_o) |=> !(|(bit_clk_o & $past(bit_clk_o))));
endmodule

// File: rtl/sar_result.sv
module sar_result #(
  parameter int NBITS = 10,
  localparam int IW = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             capture_i,
  input  logic [IW-1:0]    idx_i,
  input  logic             cmp_i,
  output logic [NBITS-1:0] code_o,
  output logic             done_o
);
  logic [NBITS-1:0] code_q;
  logic             done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= capture_i && (idx_i == '0);
      if (start_i) code_q <= '0;
      else if (capture_i) code_q[idx_i] <= cmp_i;
    end
  end

  assign code_o = code_q;
  assign done_o = done_q;

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  p_code_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> $stable(code_q));
endmodule

// File: rtl/sar_switch_bank.sv
module sar_switch_bank #(
  parameter int NCAP = 9,
  parameter int SIDE = 1,
  localparam int CIW = (NCAP > 1) ? $clog2(NCAP) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rel_i,
  input  logic            rel_side_i,
  input  logic [CIW-1:0]  rel_cap_i,
  input  logic            gnd_go_i,
  input  logic            lift_i,
  input  logic            reref_i,
  output logic [NCAP-1:0] ref_o,
  output logic [NCAP-1:0] gnd_o
);
  logic           mine;
  logic           pend_v_q;
  logic [CIW-1:0] pend_cap_q;
  logic [NCAP-1:0] ref_q;
  logic [NCAP-1:0] gnd_q;

  assign mine = rel_i && (rel_side_i == 1'(SIDE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v_q   <= 1'b0;
      pend_cap_q <= '0;
    end else if (lift_i) begin
      pend_v_q <= 1'b0;
    end else if (mine) begin
      pend_v_q   <= 1'b1;
      pend_cap_q <= rel_cap_i;
    end else if (gnd_go_i) begin
      pend_v_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < NCAP; i++) begin : g_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ref_q[i] <= 1'b1;
        gnd_q[i] <= 1'b0;
      end else begin
        if (reref_i) ref_q[i] <= 1'b1;
        else if (mine && rel_cap_i == CIW'(i)) ref_q[i] <= 1'b0;
        if (lift_i) gnd_q[i] <= 1'b0;
        else if (gnd_go_i && pend_v_q && pend_cap_q == CIW'(i)) gnd_q[i] <= 1'b1;
      end
    end

    p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(ref_q[i] && gnd_q[i]));
    p_gnd_after_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gnd_q[i]) |-> !$past(ref_q[i]));
    p_ref_after_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ref_q[i]) |-> !$past(gnd_q[i]));
    p_ref_rise_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ref_q[i]) |-> $past(reref_i));
  end

  assign ref_o = ref_q;
  assign gnd_o = gnd_q;
endmodule

// File: rtl/sar_mono_ctrl.sv
module sar_mono_ctrl
  import sar_mono_pkg::*;
#(
  parameter int NBITS    = 10,
  parameter int DEAD_CYC = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_i,
  input  logic               cmp_p_gt_i,
  output logic [NBITS-1:0]   bit_clk_o,
  output logic [NBITS-2:0]   ref_en_p_o,
  output logic [NBITS-2:0]   gnd_en_p_o,
  output logic [NBITS-2:0]   ref_en_n_o,
  output logic [NBITS-2:0]   gnd_en_n_o,
  output logic [NBITS-1:0]   code_o,
  output logic               done_o
);
  localparam int IW   = $clog2(NBITS);
  localparam int NCAP = NBITS - 1;
  localparam int CIW  = (NCAP > 1) ? $clog2(NCAP) : 1;

  logic            idle, start, capture, rel, rel_side, gnd_go, lift, reref;
  logic [IW-1:0]   idx;
  logic [CIW-1:0]  rel_cap;
  logic [1:0][NCAP-1:0] ref_bus;
  logic [1:0][NCAP-1:0] gnd_bus;

  sar_seq #(.NBITS(NBITS), .DEAD_CYC(DEAD_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .cmp_i(cmp_p_gt_i),
    .bit_clk_o(bit_clk_o), .idle_o(idle), .start_o(start),
    .capture_o(capture), .idx_o(idx), .rel_o(rel), .rel_side_o(rel_side),
    .rel_cap_o(rel_cap), .gnd_go_o(gnd_go), .lift_o(lift), .reref_o(reref)
  );

  sar_result #(.NBITS(NBITS)) u_res (
    .clk(clk), .rst_n(rst_n), .start_i(start), .capture_i(capture),
    .idx_i(idx), .cmp_i(cmp_p_gt_i), .code_o(code_o), .done_o(done_o)
  );

  for (genvar s = 0; s < 2; s++) begin : g_side
    sar_switch_bank #(.NCAP(NCAP), .SIDE(s)) u_bank (
      .clk(clk), .rst_n(rst_n), .rel_i(rel), .rel_side_i(rel_side),
      .rel_cap_i(rel_cap), .gnd_go_i(gnd_go), .lift_i(lift),
      .reref_i(reref), .ref_o(ref_bus[s]), .gnd_o(gnd_bus[s])
    );
  end

  assign ref_en_p_o = ref_bus[SIDE_P];
  assign gnd_en_p_o = gnd_bus[SIDE_P];
  assign ref_en_n_o = ref_bus[SIDE_N];
  assign gnd_en_n_o = gnd_bus[SIDE_N];

  p_sample_at_ref_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i && idle) |-> ((&ref_en_p_o) && (&ref_en_n_o)
                            && !(|gnd_en_p_o) && !(|gnd_en_n_o)));
  p_done_after_lsb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(bit_clk_o[0]));
  p_one_grounding_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(gnd_en_p_o) + $countones(gnd_en_n_o)) <=
    ($past($countones(gnd_en_p_o) + $countones(gnd_en_n_o)) + 1));
endmodule

// File: tb/sar_mono_ctrl_test.sv
module sar_mono_ctrl_test;
  localparam int NB = 10;
  localparam int DC = 1;
  localparam int NC = NB - 1;
  localparam int T_DONE = 2 + (2 + DC) * (NB - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample = 1'b0;
  logic cmp;
  logic [NB-1:0] bit_clk, code;
  logic [NC-1:0] ref_p, gnd_p, ref_n, gnd_n;
  logic done;

  int tests = 0;
  int fails = 0;
  int d0 = 1;
  int dcur;
  bit converting = 1'b0;
  bit finished = 1'b0;
  int ov_viol = 0, dead_viol = 0, mono_viol = 0;
  logic [NC-1:0] pr_ref_p, pr_ref_n, pr_gnd_p, pr_gnd_n;

  always #4 clk = ~clk;

  sar_mono_ctrl #(.NBITS(NB), .DEAD_CYC(DC)) uut (
    .clk(clk), .rst_n(rst_n), .sample_i(sample), .cmp_p_gt_i(cmp),
    .bit_clk_o(bit_clk), .ref_en_p_o(ref_p), .gnd_en_p_o(gnd_p),
    .ref_en_n_o(ref_n), .gnd_en_n_o(gnd_n), .code_o(code), .done_o(done)
  );

  // Ideal differential array: grounding cap i lowers its side by 2^(i+1) half-LSBs.
  always_comb begin
    dcur = d0;
    for (int i = 0; i < NC; i++) begin
      if (gnd_p[i]) dcur = dcur - (2 << i);
      if (gnd_n[i]) dcur = dcur + (2 << i);
    end
  end
  assign cmp = (dcur > 0);

  // R6 / R7 monitors on the plate controls
  always @(negedge clk) begin
    if (rst_n) begin
      if (((ref_p & gnd_p) | (ref_n & gnd_n)) != 0) ov_viol++;
      if (((gnd_p & ~pr_gnd_p & pr_ref_p) | (gnd_n & ~pr_gnd_n & pr_ref_n)) != 0) dead_viol++;
      if (((ref_p & ~pr_gnd_p & pr_gnd_p) != 0) ||
          ((ref_p & ~pr_ref_p & pr_gnd_p) | (ref_n & ~pr_ref_n & pr_gnd_n)) != 0) dead_viol++;
      if (converting && (((ref_p & ~pr_ref_p) | (ref_n & ~pr_ref_n)) != 0)) mono_viol++;
    end
    pr_ref_p <= ref_p; pr_ref_n <= ref_n; pr_gnd_p <= gnd_p; pr_gnd_n <= gnd_n;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic all_ref_check(input string tag);
    check(ref_p == '1 && ref_n == '1, tag, longint'({ref_p, ref_n}), (64'd1 << (2*NC)) - 1);
    check(gnd_p == '0 && gnd_n == '0, tag, longint'({gnd_p, gnd_n}), 0);
  endtask

  task automatic sample_phase(input int c);
    d0 = 2 * c - 1023;
    sample = 1'b1;
    repeat (3) @(negedge clk);
    all_ref_check("R2 plates at reference while sampling");
  endtask

  task automatic conv_body(input int c);
    bit [NB-1:0] dec;
    int nextk;
    int done_at;
    dec = '0;
    nextk = NB - 1;
    done_at = -1;
    sample = 1'b0;
    converting = 1'b1;
    for (int n = 1; n <= T_DONE + 10; n++) begin
      @(negedge clk);
      if (bit_clk != 0) begin
        check($onehot(bit_clk) && bit_clk[nextk], "R3 strobe order", bit_clk, 1 << nextk);
        check(n == 1 + (2 + DC) * (NB - 1 - nextk), "R3 strobe cycle", n,
              1 + (2 + DC) * (NB - 1 - nextk));
        if (nextk == NB - 1)
          check(gnd_p == 0 && gnd_n == 0, "R5 nothing switched before MSB",
                longint'({gnd_p, gnd_n}), 0);
        dec[nextk] = cmp;
        if (nextk > 0) nextk--;
      end
      if (done) begin
        done_at = n;
        break;
      end
    end
    converting = 1'b0;
    check(done_at == T_DONE, "R8 done timing", done_at, T_DONE);
    check(code == 10'(c), "R11 code vs ideal array", code, c);
    check(code == dec, "R4 bits follow decisions", code, dec);
    check(gnd_p == dec[NB-1:1] && gnd_n == ~dec[NB-1:1], "R5 switching pattern",
          longint'({gnd_p, gnd_n}), longint'({dec[NB-1:1], ~dec[NB-1:1]}));
    @(negedge clk);
    check(!done, "R8 done single cycle", done, 0);
    check(code == 10'(c), "R8 word held after done", code, c);
    check(gnd_p == 0 && gnd_n == 0, "R9 grounds released", longint'({gnd_p, gnd_n}), 0);
    repeat (DC) @(negedge clk);
    check(ref_p == '1 && ref_n == '1, "R9 references restored",
          longint'({ref_p, ref_n}), (64'd1 << (2*NC)) - 1);
  endtask

  task automatic abort_run(input int c, input int at);
    int seen_done;
    seen_done = 0;
    sample_phase(c);
    sample = 1'b0;
    converting = 1'b1;
    repeat (at) @(negedge clk);
    converting = 1'b0;
    sample = 1'b1;
    for (int n = 0; n < 2 + DC; n++) begin
      @(negedge clk);
      if (done) seen_done++;
    end
    check(seen_done == 0, "R10 no done on abort", seen_done, 0);
    all_ref_check("R10 plates restored after abort");
    @(negedge clk);
    conv_body(c);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (2) @(negedge clk);
    check(bit_clk == 0 && !done && code == 0, "R1 reset outputs",
          longint'({bit_clk, done, code}), 0);
    all_ref_check("R1 reset plate state");
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < (1 << NB); c++) begin
      sample_phase(c);
      conv_body(c);
    end
    abort_run(700, 12);
    abort_run(301, 2);
    abort_run(1023, 25);
    check(ov_viol == 0, "R6 no overlap", ov_viol, 0);
    check(dead_viol == 0, "R6 dead time kept", dead_viol, 0);
    check(mono_viol == 0, "R7 no reference rise in conversion", mono_viol, 0);
    summary();
  end
endmodule